// File: doc/BRIEF.md
# Line-Masked Clamp and Blank Pulser

This block drives two active-low, once-per-line timing pulses for a CCD readout chain: a dark-pixel clamp pulse and a pixel blanking pulse. A pixel counter restarts on each horizontal sync and a line counter restarts on each vertical sync. Each pulse is shaped by a start level and two toggle positions, given in pixels within the line. The start level and toggle positions come from a set of sequence registers. The sequence is picked by an external select input at the start of every line, so different parts of a field can carry different clamp and blank patterns.

Each pulse also has three line-range mask windows. A window forces its pulse inactive (high) for every line it covers, whichever sequence is active. A simple synchronous write port loads all settings. The logic that chooses sequences and the serial programming link sit outside this block.

Top module: `clamp_blank_pulser`

## Requirements
- R1: After reset both outputs are high. Every start level reads 1, every toggle reads 8191 and every mask bound reads 0xFFF, so a line run without any writes stays high throughout.
- R2: In a cycle with `hsync` high, each pulse loads the start level of the sequence named by `seq_sel` in that cycle. The level shows on the output from the next cycle, which is pixel 0.
- R3: A pulse inverts at the clock edge that ends the cycle in which the pixel counter equals one of its used toggle positions. During pixel p the output therefore equals the start level XOR the parity of the distinct used toggle positions below p.
- R4: A toggle position of 8191 is unused and never causes an inversion, including the cycles in which the pixel counter sits at 8191.
- R5: Two equal toggle positions give one inversion. The order of the two positions (first greater than second) makes no difference.
- R6: Both pulses are active low. On a masked line the pulse is held high for the whole line.
- R7: Each pulse has three mask windows with inclusive start and end lines. They are tested against the line number that the line counter takes at that line's `hsync`. A window whose start or end equals 0xFFF is disabled.
- R8: Mask windows belong to no sequence and apply to every sequence. Clamp windows and blank windows are independent.
- R9: Start level and toggles are captured at `hsync`. A change of `seq_sel` later in the line does not alter the current line.
- R10: The pixel counter is 0 in the cycle after `hsync`, then counts up by one per cycle and saturates at 8191. The line counter becomes 0 on a line whose `hsync` comes with `vsync`, counts up by one on each other `hsync`, and saturates at 4095.
- R11: The write address uses 8 bits. With bit 7 = 0, bits 6:3 give the sequence index (only values below the sequence count are stored), bit 2 gives the pulse (0 clamp, 1 blank), and bits 1:0 give the field: 0 start level in data bit 0, 1 first toggle, 2 second toggle, 3 none. With bit 7 = 1, bit 3 gives the pulse, bits 2:1 give the window (0 to 2; 3 is none) and bit 0 picks the start line (0) or the end line (1), with data in bits 11:0. Any write outside these fields changes nothing.
- R12: Clamp and blank have separate start levels, toggles and windows, and each pulse follows only its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | One-cycle line start strobe |
| vsync | input | 1 | Field start strobe, given together with `hsync` |
| seq_sel | input | 2 | Sequence index sampled at `hsync` |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 13 | Register write data |
| clamp_n | output | 1 | Active-low dark-pixel clamp pulse |
| blank_n | output | 1 | Active-low pixel blank pulse |

## Verification
The line-start level and the mask decision are due one cycle after the edge that samples `hsync`. A toggle appears one cycle after the pixel counter matches it, so the level seen during pixel p reflects all toggles below p. The bench drives `hsync` at a falling edge and reads pixel 0 at the next falling edge, then reads one pixel per falling edge after that. Its expected levels come from its own copy of the written settings and its own line count. Writes land at the next rising edge and take effect from the next `hsync`, so every write is finished before the line that should see it begins, and `seq_sel` is moved off its value right after each `hsync` to show that the line keeps its captured settings.

// File: rtl/cbp_pkg.sv
package cbp_pkg;

  localparam int unsigned PIX_W     = 13;
  localparam int unsigned LINE_W    = 12;
  localparam int unsigned NUM_PULSE = 2;
  localparam int unsigned ADDR_W    = 8;

  // write address layout
  localparam int unsigned BANK_BIT   = 7;
  localparam int unsigned SEQ_LSB    = 3;
  localparam int unsigned SEQ_FW     = 4;
  localparam int unsigned SPULSE_BIT = 2;
  localparam int unsigned FLD_LSB    = 0;
  localparam int unsigned FLD_FW     = 2;
  localparam int unsigned MPULSE_BIT = 3;
  localparam int unsigned MREG_LSB   = 1;
  localparam int unsigned MREG_FW    = 2;
  localparam int unsigned MEND_BIT   = 0;

  localparam int unsigned PULSE_CLAMP = 0;
  localparam int unsigned PULSE_BLANK = 1;

  typedef logic [PIX_W-1:0]  pix_t;
  typedef logic [LINE_W-1:0] line_t;

  localparam pix_t  PIX_MAX  = {PIX_W{1'b1}};
  localparam line_t LINE_MAX = {LINE_W{1'b1}};

  typedef enum logic [FLD_FW-1:0] {
    FLD_POL  = 2'd0,
    FLD_TOG1 = 2'd1,
    FLD_TOG2 = 2'd2,
    FLD_NONE = 2'd3
  } seq_fld_e;

  typedef struct packed {
    logic pol;
    pix_t tog1;
    pix_t tog2;
  } pulse_cfg_t;

  localparam pulse_cfg_t CFG_RESET = '{pol: 1'b1, tog1: PIX_MAX, tog2: PIX_MAX};

  // a toggle position fires only when it is in use and matches the count
  function automatic logic tog_hit(input pix_t pix, input pix_t tog);
    return (tog != PIX_MAX) && (pix == tog);
  endfunction

  // a mask window is live only when neither bound holds the disable code
  function automatic logic window_live(input line_t lo, input line_t hi);
    return (lo != LINE_MAX) && (hi != LINE_MAX);
  endfunction

  function automatic logic line_in_window(input line_t ln, input line_t lo, input line_t hi);
    return window_live(lo, hi) && (ln >= lo) && (ln <= hi);
  endfunction

  function automatic pix_t pix_step(input pix_t pix);
    return (pix == PIX_MAX) ? pix : pix + pix_t'(1);
  endfunction

  function automatic line_t line_step(input line_t ln);
    return (ln == LINE_MAX) ? ln : ln + line_t'(1);
  endfunction

endpackage

// File: rtl/cbp_counters.sv
module cbp_counters
  import cbp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hsync,
  input  logic  vsync,
  output pix_t  pix_cnt,
  output line_t line_cnt,
  output line_t line_up
);

  // number the line about to begin, for mask evaluation at hsync
  assign line_up = vsync ? '0 : line_step(line_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_cnt <= PIX_MAX;
    end else if (hsync) begin
      pix_cnt <= '0;
    end else begin
      pix_cnt <= pix_step(pix_cnt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_cnt <= '0;
    end else if (vsync) begin
      line_cnt <= '0;
    end else if (hsync) begin
      line_cnt <= line_step(line_cnt);
    end
  end

endmodule

// File: rtl/cbp_regfile.sv
module cbp_regfile
  import cbp_pkg::*;
#(
  parameter int unsigned NUM_SEQ  = 4,
  parameter int unsigned NUM_MASK = 3,
  parameter int unsigned SEL_W    = $clog2(NUM_SEQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  pix_t              wr_data,
  input  logic [SEL_W-1:0]  rd_seq,
  output pulse_cfg_t        cfg_sel [NUM_PULSE],
  output line_t             msk_lo  [NUM_PULSE][NUM_MASK],
  output line_t             msk_hi  [NUM_PULSE][NUM_MASK]
);

  logic     seq_bank;
  logic     msk_bank;
  seq_fld_e fld;

  assign seq_bank = wr_en && !wr_addr[BANK_BIT];
  assign msk_bank = wr_en &&  wr_addr[BANK_BIT];
  assign fld      = seq_fld_e'(wr_addr[FLD_LSB +: FLD_FW]);

  pulse_cfg_t cfg_all [NUM_SEQ][NUM_PULSE];

  for (genvar s = 0; s < NUM_SEQ; s++) begin : g_seq
    for (genvar p = 0; p < NUM_PULSE; p++) begin : g_pulse
      pulse_cfg_t cell_q;
      logic       sel;

      assign sel = seq_bank
                && (wr_addr[SEQ_LSB +: SEQ_FW] == SEQ_FW'(s))
                && (wr_addr[SPULSE_BIT] == 1'(p));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cell_q <= CFG_RESET;
        end else if (sel) begin
          case (fld)
            FLD_POL:  cell_q.pol  <= wr_data[0];
            FLD_TOG1: cell_q.tog1 <= wr_data;
            FLD_TOG2: cell_q.tog2 <= wr_data;
            default:  cell_q      <= cell_q;
          endcase
        end
      end

      assign cfg_all[s][p] = cell_q;
    end
  end

  logic rd_ok;
  assign rd_ok = (int'(rd_seq) < NUM_SEQ);

  always_comb begin
    for (int p = 0; p < NUM_PULSE; p++) begin
      cfg_sel[p] = rd_ok ? cfg_all[rd_seq][p] : CFG_RESET;
    end
  end

  for (genvar p = 0; p < NUM_PULSE; p++) begin : g_mpulse
    for (genvar r = 0; r < NUM_MASK; r++) begin : g_win
      line_t lo_q;
      line_t hi_q;
      logic  sel;

      assign sel = msk_bank
                && (wr_addr[MPULSE_BIT] == 1'(p))
                && (wr_addr[MREG_LSB +: MREG_FW] == MREG_FW'(r));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lo_q <= LINE_MAX;
          hi_q <= LINE_MAX;
        end else if (sel) begin
          if (wr_addr[MEND_BIT]) hi_q <= wr_data[LINE_W-1:0];
          else                   lo_q <= wr_data[LINE_W-1:0];
        end
      end

      assign msk_lo[p][r] = lo_q;
      assign msk_hi[p][r] = hi_q;
    end
  end

endmodule

// File: rtl/cbp_mask_unit.sv
module cbp_mask_unit
  import cbp_pkg::*;
#(
  parameter int unsigned NUM_MASK = 3
) (
  input  line_t line_up,
  input  line_t lo [NUM_MASK],
  input  line_t hi [NUM_MASK],
  output logic  hit
);

  logic [NUM_MASK-1:0] win_hit;

  for (genvar r = 0; r < NUM_MASK; r++) begin : g_win
    assign win_hit[r] = line_in_window(line_up, lo[r], hi[r]);
  end

  assign hit = |win_hit;

endmodule

// File: rtl/cbp_pulse_gen.sv
module cbp_pulse_gen
  import cbp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_start,
  input  pulse_cfg_t cfg_in,
  input  logic       mask_in,
  input  pix_t       pix_cnt,
  output logic       pulse_n,
  output logic       lvl,
  output logic       masked,
  output logic       tog_evt
);

  pulse_cfg_t cfg_q;

  assign tog_evt = tog_hit(pix_cnt, cfg_q.tog1) | tog_hit(pix_cnt, cfg_q.tog2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RESET;
      lvl    <= 1'b1;
      masked <= 1'b0;
    end else if (line_start) begin
      cfg_q  <= cfg_in;
      lvl    <= cfg_in.pol;
      masked <= mask_in;
    end else if (tog_evt) begin
      lvl    <= ~lvl;
    end
  end

  // active low: a masked line is forced to the idle high level
  assign pulse_n = lvl | masked;

endmodule

// File: rtl/clamp_blank_pulser.sv
module clamp_blank_pulser
  import cbp_pkg::*;
#(
  parameter int unsigned NUM_SEQ  = 4,
  parameter int unsigned NUM_MASK = 3,
  parameter int unsigned SEL_W    = $clog2(NUM_SEQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              vsync,
  input  logic [SEL_W-1:0]  seq_sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PIX_W-1:0]  wr_data,
  output logic              clamp_n,
  output logic              blank_n
);

  pix_t       pix_cnt;
  line_t      line_cnt;
  line_t      line_up;
  pulse_cfg_t cfg_sel [NUM_PULSE];
  line_t      msk_lo  [NUM_PULSE][NUM_MASK];
  line_t      msk_hi  [NUM_PULSE][NUM_MASK];

  // named internal events, observed by the bound checker
  logic [NUM_PULSE-1:0] pulse_n_w;
  logic [NUM_PULSE-1:0] lvl_w;
  logic [NUM_PULSE-1:0] masked_w;
  logic [NUM_PULSE-1:0] tog_evt_w;
  logic [NUM_PULSE-1:0] pol_start_w;
  logic [NUM_PULSE-1:0] mask_start_w;

  cbp_counters u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .hsync    (hsync),
    .vsync    (vsync),
    .pix_cnt  (pix_cnt),
    .line_cnt (line_cnt),
    .line_up  (line_up)
  );

  cbp_regfile #(
    .NUM_SEQ  (NUM_SEQ),
    .NUM_MASK (NUM_MASK),
    .SEL_W    (SEL_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_seq  (seq_sel),
    .cfg_sel (cfg_sel),
    .msk_lo  (msk_lo),
    .msk_hi  (msk_hi)
  );

  for (genvar p = 0; p < NUM_PULSE; p++) begin : g_pulse
    cbp_mask_unit #(
      .NUM_MASK (NUM_MASK)
    ) u_mask (
      .line_up (line_up),
      .lo      (msk_lo[p]),
      .hi      (msk_hi[p]),
      .hit     (mask_start_w[p])
    );

    assign pol_start_w[p] = cfg_sel[p].pol;

    cbp_pulse_gen u_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_start (hsync),
      .cfg_in     (cfg_sel[p]),
      .mask_in    (mask_start_w[p]),
      .pix_cnt    (pix_cnt),
      .pulse_n    (pulse_n_w[p]),
      .lvl        (lvl_w[p]),
      .masked     (masked_w[p]),
      .tog_evt    (tog_evt_w[p])
    );
  end

  assign clamp_n = pulse_n_w[PULSE_CLAMP];
  assign blank_n = pulse_n_w[PULSE_BLANK];

endmodule

// File: rtl/cbp_checker.sv
module cbp_checker
  import cbp_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 hsync,
  input logic                 vsync,
  input pix_t                 pix_cnt,
  input line_t                line_cnt,
  input logic [NUM_PULSE-1:0] lvl_w,
  input logic [NUM_PULSE-1:0] masked_w,
  input logic [NUM_PULSE-1:0] tog_evt_w,
  input logic [NUM_PULSE-1:0] pol_start_w,
  input logic [NUM_PULSE-1:0] mask_start_w,
  input logic                 clamp_n,
  input logic                 blank_n
);

  a_r10_pix_restart: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |=> (pix_cnt == '0));

  a_r10_pix_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync && pix_cnt == PIX_MAX) |=> (pix_cnt == PIX_MAX));

  a_r10_line_restart: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> (line_cnt == '0));

  a_r10_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync && !vsync) |=> $stable(line_cnt));

  a_r6_clamp_masked_high: assert property (@(posedge clk) disable iff (!rst_n)
    masked_w[PULSE_CLAMP] |-> clamp_n);

  a_r6_blank_masked_high: assert property (@(posedge clk) disable iff (!rst_n)
    masked_w[PULSE_BLANK] |-> blank_n);

  for (genvar i = 0; i < NUM_PULSE; i++) begin : g_chk
    a_r2_start_level: assert property (@(posedge clk) disable iff (!rst_n)
      hsync |=> (lvl_w[i] == $past(pol_start_w[i])));

    a_r3_toggle_inverts: assert property (@(posedge clk) disable iff (!rst_n)
      (!hsync && tog_evt_w[i]) |=> (lvl_w[i] != $past(lvl_w[i])));

    a_r4_no_toggle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!hsync && !tog_evt_w[i]) |=> $stable(lvl_w[i]));

    a_r4_unused_position: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_cnt == PIX_MAX) |-> !tog_evt_w[i]);

    a_r7_mask_latched: assert property (@(posedge clk) disable iff (!rst_n)
      hsync |=> (masked_w[i] == $past(mask_start_w[i])));

    a_r7_mask_steady: assert property (@(posedge clk) disable iff (!rst_n)
      !hsync |=> $stable(masked_w[i]));
  end

endmodule

bind clamp_blank_pulser cbp_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hsync        (hsync),
  .vsync        (vsync),
  .pix_cnt      (pix_cnt),
  .line_cnt     (line_cnt),
  .lvl_w        (lvl_w),
  .masked_w     (masked_w),
  .tog_evt_w    (tog_evt_w),
  .pol_start_w  (pol_start_w),
  .mask_start_w (mask_start_w),
  .clamp_n      (clamp_n),
  .blank_n      (blank_n)
);

// File: tb/tb_clamp_blank_pulser.sv
module tb_clamp_blank_pulser;

  localparam int NSEQ  = 4;
  localparam int NWIN  = 3;
  localparam int UNUSED = 8191;
  localparam int OFF    = 4095;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hsync = 1'b0;
  logic        vsync = 1'b0;
  logic [1:0]  seq_sel = 2'd0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = 8'd0;
  logic [12:0] wr_data = 13'd0;
  logic        clamp_n;
  logic        blank_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // bench's own copy of written settings
  bit m_pol [NSEQ][2];
  int m_t1  [NSEQ][2];
  int m_t2  [NSEQ][2];
  int m_lo  [2][NWIN];
  int m_hi  [2][NWIN];
  int bline = 0;

  always #4 clk = ~clk;

  clamp_blank_pulser dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .hsync   (hsync),
    .vsync   (vsync),
    .seq_sel (seq_sel),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .clamp_n (clamp_n),
    .blank_n (blank_n)
  );

  function automatic logic [7:0] seq_addr(int s, int p, int f);
    return {1'b0, 4'(s), 1'(p), 2'(f)};
  endfunction

  function automatic logic [7:0] win_addr(int p, int w, int e);
    return {1'b1, 3'b000, 1'(p), 2'(w), 1'(e)};
  endfunction

  function automatic bit line_masked(int p, int ln);
    for (int w = 0; w < NWIN; w++)
      if (m_lo[p][w] != OFF && m_hi[p][w] != OFF && ln >= m_lo[p][w] && ln <= m_hi[p][w])
        return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit exp_level(bit pol, int t1, int t2, int px);
    bit v = pol;
    if (t1 != UNUSED && t1 < px) v = ~v;
    if (t2 != UNUSED && t2 < px && t2 != t1) v = ~v;
    return v;
  endfunction

  task automatic wr(input logic [7:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = 13'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_seq(int s, int p, bit pol, int t1, int t2);
    wr(seq_addr(s, p, 0), int'(pol));
    wr(seq_addr(s, p, 1), t1);
    wr(seq_addr(s, p, 2), t2);
    m_pol[s][p] = pol; m_t1[s][p] = t1; m_t2[s][p] = t2;
  endtask

  task automatic set_win(int p, int w, int lo, int hi);
    wr(win_addr(p, w, 0), lo);
    wr(win_addr(p, w, 1), hi);
    m_lo[p][w] = lo; m_hi[p][w] = hi;
  endtask

  // one line: hsync at a falling edge, pixels sampled at later falling edges
  task automatic run_line(int s, bit vs, int len, string tag);
    bit msk [2];
    int bad [2];
    int bad_px [2];
    bit bad_act [2];
    bit bad_exp [2];
    bline = vs ? 0 : ((bline >= OFF) ? OFF : bline + 1);
    for (int p = 0; p < 2; p++) begin
      msk[p] = line_masked(p, bline);
      bad[p] = 0;
    end
    @(negedge clk);
    hsync = 1'b1; vsync = vs; seq_sel = 2'(s);
    @(negedge clk);
    hsync = 1'b0; vsync = 1'b0; seq_sel = 2'(s ^ 1);
    for (int px = 0; px < len; px++) begin
      for (int p = 0; p < 2; p++) begin
        bit act = (p == 0) ? clamp_n : blank_n;
        bit ex  = msk[p] ? 1'b1 : exp_level(m_pol[s][p], m_t1[s][p], m_t2[s][p], px);
        if (act !== ex && bad[p] == 0) begin
          bad_px[p] = px; bad_act[p] = act; bad_exp[p] = ex;
        end
        if (act !== ex) bad[p]++;
      end
      if (px < len - 1) @(negedge clk);
    end
    for (int p = 0; p < 2; p++) begin
      checks++;
      if (bad[p] != 0) begin
        errors++;
        $display("FAIL %s line %0d pulse %0d pixel %0d act %0b exp %0b",
                 tag, bline, p, bad_px[p], bad_act[p], bad_exp[p]);
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    checks++;
    if (clamp_n !== 1'b1 || blank_n !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset outputs act %0b%0b exp 11", clamp_n, blank_n);
    end
    run_line(0, 1'b1, 24, "R1 defaults");
    run_line(3, 1'b0, 24, "R1 defaults seq3");
  endtask

  task automatic t_basic();
    set_seq(0, 0, 1'b1, 4, 9);
    set_seq(0, 1, 1'b1, 2, 15);
    run_line(0, 1'b1, 20, "R2 R3 R12 basic");
    set_seq(1, 0, 1'b0, 3, UNUSED);
    set_seq(1, 1, 1'b1, UNUSED, 7);
    run_line(1, 1'b0, 14, "R2 R4 start low, one toggle");
  endtask

  task automatic t_edges();
    set_seq(2, 0, 1'b1, 0, 0);
    set_seq(2, 1, 1'b0, 6, 6);
    run_line(2, 1'b0, 12, "R5 equal toggles");
    set_seq(2, 0, 1'b1, 10, 3);
    set_seq(2, 1, 1'b0, 11, 1);
    run_line(2, 1'b0, 16, "R5 reversed order");
    run_line(0, 1'b0, 20, "R9 seq0 after seq2");
  endtask

  task automatic t_masks();
    set_win(0, 0, 2, 3);
    set_win(0, 1, 5, 5);
    set_win(0, 2, 7, OFF);
    set_win(1, 0, 4, 4);
    set_win(1, 1, OFF, 6);
    set_seq(1, 0, 1'b0, 5, 9);
    set_seq(1, 1, 1'b0, 3, UNUSED);
    run_line(0, 1'b1, 14, "R7 line0");
    for (int ln = 1; ln <= 8; ln++)
      run_line(ln % 2, 1'b0, 14, "R6 R7 R8 masked field");
  endtask

  task automatic t_unmapped();
    wr({1'b0, 4'd4, 1'b0, 2'd1}, 1);
    wr(seq_addr(0, 0, 3), 2);
    wr(win_addr(0, 3, 0), 0);
    wr(win_addr(0, 3, 1), 4094);
    run_line(0, 1'b1, 20, "R11 ignored writes");
    run_line(0, 1'b0, 20, "R11 ignored writes line1");
  endtask

  task automatic t_long_line();
    set_seq(3, 0, 1'b1, 5, 8190);
    set_seq(3, 1, 1'b0, 8191, 8189);
    run_line(3, 1'b1, 8220, "R10 R4 pixel saturation");
  endtask

  task automatic t_line_sat();
    set_win(0, 0, OFF, OFF);
    set_win(0, 1, OFF, OFF);
    set_win(0, 2, OFF, OFF);
    set_win(1, 0, 0, 0);
    set_win(1, 1, OFF, OFF);
    set_win(1, 2, 4095, 4095);
    set_seq(3, 1, 1'b0, UNUSED, UNUSED);
    run_line(3, 1'b1, 2, "R10 line0");
    for (int ln = 1; ln < 4102; ln++)
      run_line(3, 1'b0, 2, "R10 line saturation");
    run_line(3, 1'b1, 2, "R10 line restart");
  endtask

  initial begin
    for (int s = 0; s < NSEQ; s++)
      for (int p = 0; p < 2; p++) begin
        m_pol[s][p] = 1'b1; m_t1[s][p] = UNUSED; m_t2[s][p] = UNUSED;
      end
    for (int p = 0; p < 2; p++)
      for (int w = 0; w < NWIN; w++) begin
        m_lo[p][w] = OFF; m_hi[p][w] = OFF;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_edges();
    t_masks();
    t_unmapped();
    t_long_line();
    t_line_sat();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog act %0d cycles exp below 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule